// File: doc/BRIEF.md
# Capability Memory Operand Checker

This unit sits after address generation and decides, for a single decoded memory operand, which capability grants the access. It then checks that access against that capability. Three candidates arrive with every request: the default data capability, the instruction capability and the capability held in the operand's base register. Each carries a tag, a base, a top and a permission field. The choice depends on the execution mode, on whether the addressing-toggle prefix is present, and on the operand form.

Under capability-aware addressing, a register-based operand is authorised by its base register's capability, and a RIP-relative operand is authorised by the instruction capability. Under plain addressing, both forms fall back to the default data capability. Operands without a base register always use the default data capability. Integer addresses are treated as absolute virtual addresses. They are compared against the chosen bounds directly and are never offset by the capability's base.

The verdict is registered. One cycle after a valid request, the unit reports either a pass or a fault with a two-bit cause.

Top module: `cap_opnd_check`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release with no request, `outValid`, `outPass`, `outFault` and `faultCause` are all zero.
- R2: A request presented with `inValid` high at a rising edge produces `outValid` high after that edge, for exactly that cycle. With `inValid` low, `outValid`, `outPass` and `outFault` are low after the edge.
- R3: Addressing is capability-aware when `capMode` XOR `altPrefix` is 1. A register-based operand (`opForm` = 0) is authorised by the base register capability when capability-aware, and by the default data capability otherwise.
- R4: A RIP-relative operand (`opForm` = 1) is authorised by the instruction capability when capability-aware, and by the default data capability otherwise.
- R5: An operand with no base register (`opForm` = 2 or 3) is always authorised by the default data capability, whatever the values of `capMode` and `altPrefix`.
- R6: The bounds hold only if `base <= addr` and `addr + accSize <= top`. The sum is formed one bit wider than the address, so it never wraps. A bounds violation reports cause 3.
- R7: If the authorising capability's tag is clear, the access faults with cause 1.
- R8: A load (`isStore` = 0) needs permission bit 0, and a store (`isStore` = 1) needs permission bit 1. If the needed bit is missing, the access faults with cause 2.
- R9: When several checks fail, the reported cause follows the order tag (1), then permission (2), then bounds (3). A passing access reports cause 0.
- R10: While `outValid` is high, exactly one of `outPass` and `outFault` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present this cycle |
| capMode | input | 1 | 1 = capability mode, 0 = plain 64-bit mode |
| altPrefix | input | 1 | Addressing-toggle prefix present |
| opForm | input | 2 | 0 register-based, 1 RIP-relative, 2/3 no base register |
| isStore | input | 1 | 1 = store, 0 = load |
| addr | input | ADDR_W | Effective virtual address |
| accSize | input | SIZE_W | Access size in bytes |
| ddcTag | input | 1 | Default data capability tag |
| ddcBase | input | ADDR_W | Default data capability base |
| ddcTop | input | ADDR_W | Default data capability top (exclusive) |
| ddcPerm | input | PERM_W | Default data capability permissions |
| insTag | input | 1 | Instruction capability tag |
| insBase | input | ADDR_W | Instruction capability base |
| insTop | input | ADDR_W | Instruction capability top (exclusive) |
| insPerm | input | PERM_W | Instruction capability permissions |
| regTag | input | 1 | Base register capability tag |
| regBase | input | ADDR_W | Base register capability base |
| regTop | input | ADDR_W | Base register capability top (exclusive) |
| regPerm | input | PERM_W | Base register capability permissions |
| outValid | output | 1 | Verdict valid |
| outPass | output | 1 | Access allowed |
| outFault | output | 1 | Access refused |
| faultCause | output | 2 | 0 none, 1 tag, 2 permission, 3 bounds |

## Verification
The three capabilities are given overlapping but distinct windows, tags and permissions. A wrong choice of authority, such as inverting the prefix, consulting the base register for a no-base operand, or never using the instruction capability, therefore shows up as the wrong pass or cause.

Several corner cases are aimed at directly:
- An address below the default data capability's base must fault. A design that relocates by the base would accept it.
- An access whose end crosses the top of the address space must fault. A sum that wraps would pass it.
- An access ending exactly at top must pass. An off-by-one comparison would reject it.
- Accesses that fail tag, permission and bounds together expose any swapped priority in the cause.

// File: rtl/cap_opnd_pkg.sv
package cap_opnd_pkg;

  typedef enum logic [1:0] {
    FORM_REG = 2'd0,
    FORM_RIP = 2'd1,
    FORM_ABS = 2'd2,
    FORM_IDX = 2'd3
  } opForm_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_TAG    = 2'd1,
    CAUSE_PERM   = 2'd2,
    CAUSE_BOUNDS = 2'd3
  } cause_e;

  // strobes from the control decode to the datapath
  typedef struct packed {
    logic capture;
    logic useDdc;
    logic useIns;
    logic useReg;
    logic wantStore;
  } ctrlStrobe_t;

endpackage

// File: rtl/cap_opnd_ctrl.sv
module cap_opnd_ctrl
  import cap_opnd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        capMode,
  input  logic        altPrefix,
  input  logic [1:0]  opForm,
  input  logic        isStore,
  output ctrlStrobe_t strobe
);

  logic    capAware;
  opForm_e form;

  assign capAware = capMode ^ altPrefix;
  assign form     = opForm_e'(opForm);

  always_comb begin
    strobe           = '0;
    strobe.capture   = inValid;
    strobe.wantStore = isStore;
    unique case (form)
      FORM_REG: begin
        strobe.useReg = capAware;
        strobe.useDdc = !capAware;
      end
      FORM_RIP: begin
        strobe.useIns = capAware;
        strobe.useDdc = !capAware;
      end
      default: strobe.useDdc = 1'b1;
    endcase
  end

  AST_NOBASE_DDC: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opForm[1]) |-> (strobe.useDdc && !strobe.useReg && !strobe.useIns)); // R5

  AST_PLAIN_NO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && (capMode == altPrefix)) |-> !strobe.useReg && !strobe.useIns); // R3

endmodule

// File: rtl/cap_opnd_dp.sv
module cap_opnd_dp
  import cap_opnd_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int SIZE_W    = 5,
  parameter int PERM_W    = 2,
  parameter int LOAD_BIT  = 0,
  parameter int STORE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] accSize,
  input  logic              ddcTag,
  input  logic [ADDR_W-1:0] ddcBase,
  input  logic [ADDR_W-1:0] ddcTop,
  input  logic [PERM_W-1:0] ddcPerm,
  input  logic              insTag,
  input  logic [ADDR_W-1:0] insBase,
  input  logic [ADDR_W-1:0] insTop,
  input  logic [PERM_W-1:0] insPerm,
  input  logic              regTag,
  input  logic [ADDR_W-1:0] regBase,
  input  logic [ADDR_W-1:0] regTop,
  input  logic [PERM_W-1:0] regPerm,
  output logic              outValid,
  output logic              outPass,
  output logic              outFault,
  output logic [1:0]        faultCause
);

  localparam int EXT_W = ADDR_W + 1;

  logic              selTag;
  logic [ADDR_W-1:0] selBase;
  logic [ADDR_W-1:0] selTop;
  logic [PERM_W-1:0] selPerm;
  logic [EXT_W-1:0]  endAddr;
  logic              lowOk, highOk, permOk;
  cause_e            nextCause;

  // authority mux
  always_comb begin
    selTag  = ddcTag;
    selBase = ddcBase;
    selTop  = ddcTop;
    selPerm = ddcPerm;
    if (strobe.useIns) begin
      selTag  = insTag;
      selBase = insBase;
      selTop  = insTop;
      selPerm = insPerm;
    end else if (strobe.useReg) begin
      selTag  = regTag;
      selBase = regBase;
      selTop  = regTop;
      selPerm = regPerm;
    end
  end

  // absolute bounds, no relocation, widened sum
  assign endAddr = {1'b0, addr} + EXT_W'(accSize);
  assign lowOk   = addr >= selBase;
  assign highOk  = endAddr <= {1'b0, selTop};
  assign permOk  = strobe.wantStore ? selPerm[STORE_BIT] : selPerm[LOAD_BIT];

  always_comb begin
    if (!selTag)               nextCause = CAUSE_TAG;
    else if (!permOk)          nextCause = CAUSE_PERM;
    else if (!lowOk || !highOk) nextCause = CAUSE_BOUNDS;
    else                       nextCause = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid   <= 1'b0;
      outPass    <= 1'b0;
      outFault   <= 1'b0;
      faultCause <= 2'd0;
    end else begin
      outValid   <= strobe.capture;
      outPass    <= strobe.capture && (nextCause == CAUSE_NONE);
      outFault   <= strobe.capture && (nextCause != CAUSE_NONE);
      faultCause <= strobe.capture ? nextCause : CAUSE_NONE;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |-> $onehot({strobe.useDdc, strobe.useIns, strobe.useReg})); // R3

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |=> outValid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> (!outPass && !outFault)); // R2

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> ($countones({outPass, outFault}) == 1)); // R10

  AST_PASS_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    outPass |-> (faultCause == 2'd0)); // R9

  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    outFault |-> (faultCause != 2'd0)); // R9

  AST_UNTAGGED_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capture && !selTag) |=> (outFault && faultCause == 2'd1)); // R7

endmodule

// File: rtl/cap_opnd_check.sv
module cap_opnd_check
  import cap_opnd_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 5,
  parameter int PERM_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic              capMode,
  input  logic              altPrefix,
  input  logic [1:0]        opForm,
  input  logic              isStore,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] accSize,
  input  logic              ddcTag,
  input  logic [ADDR_W-1:0] ddcBase,
  input  logic [ADDR_W-1:0] ddcTop,
  input  logic [PERM_W-1:0] ddcPerm,
  input  logic              insTag,
  input  logic [ADDR_W-1:0] insBase,
  input  logic [ADDR_W-1:0] insTop,
  input  logic [PERM_W-1:0] insPerm,
  input  logic              regTag,
  input  logic [ADDR_W-1:0] regBase,
  input  logic [ADDR_W-1:0] regTop,
  input  logic [PERM_W-1:0] regPerm,
  output logic              outValid,
  output logic              outPass,
  output logic              outFault,
  output logic [1:0]        faultCause
);

  ctrlStrobe_t strobe;

  cap_opnd_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .inValid   (inValid),
    .capMode   (capMode),
    .altPrefix (altPrefix),
    .opForm    (opForm),
    .isStore   (isStore),
    .strobe    (strobe)
  );

  cap_opnd_dp #(
    .ADDR_W    (ADDR_W),
    .SIZE_W    (SIZE_W),
    .PERM_W    (PERM_W),
    .LOAD_BIT  (0),
    .STORE_BIT (1)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .addr       (addr),
    .accSize    (accSize),
    .ddcTag     (ddcTag),
    .ddcBase    (ddcBase),
    .ddcTop     (ddcTop),
    .ddcPerm    (ddcPerm),
    .insTag     (insTag),
    .insBase    (insBase),
    .insTop     (insTop),
    .insPerm    (insPerm),
    .regTag     (regTag),
    .regBase    (regBase),
    .regTop     (regTop),
    .regPerm    (regPerm),
    .outValid   (outValid),
    .outPass    (outPass),
    .outFault   (outFault),
    .faultCause (faultCause)
  );

endmodule

// File: tb/cap_opnd_check_tb.sv
`timescale 1ns/1ps
module cap_opnd_check_tb;

  localparam int AW = 8;
  localparam int SW = 4;
  localparam int PW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, inValid, capMode, altPrefix, isStore;
  logic [1:0]    opForm;
  logic [AW-1:0] addr;
  logic [SW-1:0] accSize;
  logic          ddcTag, insTag, regTag;
  logic [AW-1:0] ddcBase, ddcTop, insBase, insTop, regBase, regTop;
  logic [PW-1:0] ddcPerm, insPerm, regPerm;
  logic          outValid, outPass, outFault;
  logic [1:0]    faultCause;

  cap_opnd_check #(.ADDR_W(AW), .SIZE_W(SW), .PERM_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .capMode(capMode),
    .altPrefix(altPrefix), .opForm(opForm), .isStore(isStore),
    .addr(addr), .accSize(accSize),
    .ddcTag(ddcTag), .ddcBase(ddcBase), .ddcTop(ddcTop), .ddcPerm(ddcPerm),
    .insTag(insTag), .insBase(insBase), .insTop(insTop), .insPerm(insPerm),
    .regTag(regTag), .regBase(regBase), .regTop(regTop), .regPerm(regPerm),
    .outValid(outValid), .outPass(outPass), .outFault(outFault),
    .faultCause(faultCause)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // independent reference: returns expected cause (0 = pass)
  function automatic int refCause(input bit cm, input bit pre, input int form,
                                  input bit st, input int a, input int sz);
    bit aware;
    int sel; // 0 ddc, 1 ins, 2 reg
    bit t;
    int b, tp, p;
    aware = cm ^ pre;
    if (form == 0)      sel = aware ? 2 : 0;
    else if (form == 1) sel = aware ? 1 : 0;
    else                sel = 0;
    case (sel)
      1:       begin t = insTag; b = insBase; tp = insTop; p = insPerm; end
      2:       begin t = regTag; b = regBase; tp = regTop; p = regPerm; end
      default: begin t = ddcTag; b = ddcBase; tp = ddcTop; p = ddcPerm; end
    endcase
    if (!t) return 1;
    if (st ? !p[1] : !p[0]) return 2;
    if (a < b || a + sz > tp) return 3;
    return 0;
  endfunction

  task automatic issue(input bit cm, input bit pre, input int form, input bit st,
                       input int a, input int sz, input string req);
    int ec;
    ec        = refCause(cm, pre, form, st, a, sz);
    inValid   = 1'b1;
    capMode   = cm;
    altPrefix = pre;
    opForm    = form[1:0];
    isStore   = st;
    addr      = a[AW-1:0];
    accSize   = sz[SW-1:0];
    @(negedge clk);
    inValid = 1'b0;
    check(outValid === 1'b1, {req, " R2 valid"}, int'(outValid), 1);
    check((outPass === (ec == 0)) && (outFault === (ec != 0)),
          {req, " R10 verdict"}, int'({outPass, outFault}), (ec == 0) ? 2 : 1);
    check(faultCause === ec[1:0], {req, " R9 cause"}, int'(faultCause), ec);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; inValid = 1'b0; capMode = 1'b0; altPrefix = 1'b0;
    opForm = 2'd0; isStore = 1'b0; addr = '0; accSize = '0;
    ddcTag = 1'b1; ddcBase = 8'd16;  ddcTop = 8'd96;  ddcPerm = 2'b11;
    insTag = 1'b1; insBase = 8'd64;  insTop = 8'd160; insPerm = 2'b01;
    regTag = 1'b1; regBase = 8'd128; regTop = 8'd250; regPerm = 2'b10;
    repeat (3) @(negedge clk);
    check(!outValid && !outPass && !outFault && faultCause == 2'd0,
          "R1 reset", int'({outValid, outPass, outFault, faultCause}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!outValid && !outPass && !outFault && faultCause == 2'd0,
          "R1 post-reset idle", int'({outValid, outPass, outFault, faultCause}), 0);

    // directed: no relocation by base (R6)
    issue(1'b0, 1'b0, 2, 1'b0, 10, 1, "R6 below-base");
    // quiet cycle after a valid (R2)
    @(negedge clk);
    check(!outValid && !outPass && !outFault, "R2 idle",
          int'({outValid, outPass, outFault}), 0);
    // no-base form in capability mode still uses default data cap (R5)
    issue(1'b1, 1'b0, 3, 1'b1, 20, 4, "R5 idx capmode");

    // wrap and exact-fit at address-space top (R6)
    regBase = 8'd0; regTop = 8'd255; regPerm = 2'b11;
    issue(1'b1, 1'b0, 0, 1'b0, 252, 8, "R6 wrap");
    issue(1'b1, 1'b0, 0, 1'b0, 247, 8, "R6 exact-top");
    issue(1'b1, 1'b0, 0, 1'b1, 0, 1, "R6 zero-base");
    regBase = 8'd128; regTop = 8'd250; regPerm = 2'b10;

    // priority with all checks failing at once (R7, R8, R9)
    insTag = 1'b0;
    issue(1'b1, 1'b0, 1, 1'b1, 200, 8, "R7 R9 untagged");
    insTag = 1'b1;
    issue(1'b1, 1'b0, 1, 1'b1, 200, 8, "R8 R9 perm-before-bounds");
    issue(1'b1, 1'b0, 1, 1'b0, 200, 8, "R6 R9 bounds");

    // near-exhaustive sweep
    for (int t = 0; t < 8; t++) begin
      ddcTag = t[0]; insTag = t[1]; regTag = t[2];
      for (int cm = 0; cm < 2; cm++)
        for (int pre = 0; pre < 2; pre++)
          for (int f = 0; f < 4; f++)
            for (int st = 0; st < 2; st++)
              for (int k = 0; k < 64; k++)
                for (int s = 0; s < 4; s++) begin
                  string req;
                  req = (f == 0) ? "R3 sweep" : (f == 1) ? "R4 sweep" : "R5 sweep";
                  issue(cm[0], pre[0], f, st[0], k * 4 + (k % 3), 1 << s, req);
                end
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule